// File: doc/BRIEF.md
# Quad 12-bit converter double-buffered input interface

This block is the digital front end of a four-channel, 12-bit converter. A host drives a parallel data bus, a 2-bit channel address and a set of active-low strobes. Each channel has two storage stages: a staging register, written from the bus, and an output register, whose value is the code presented to the converter. All output registers can be updated together from their staging registers, and all of them can be forced to midscale (`0x800`), which is zero output in offset binary.

Both stages behave like level-sensitive latches, modelled synchronously on `clk`. A stage whose enable is active updates on every rising edge. Through a combinational bypass, its output equals its new value in the same cycle. A byte-mode select lets an 8-bit host assemble a 12-bit word in two writes. Holding the strobes of the second stage low makes that stage transparent. Holding all strobes low gives a path that is transparent from the bus to the addressed channel.

The output stage is governed by a small state machine with three states, decoded from the strobes each cycle:
- `ST_HOLD`: the output registers keep their value.
- `ST_FOLLOW`: every output register tracks its staging register.
- `ST_CLEAR`: every output register is forced to midscale.

The decode is fresh each cycle, so any state may move to any other. The transitions are:
- HOLD→FOLLOW and CLEAR→FOLLOW, when transfer is asserted.
- HOLD→CLEAR and FOLLOW→CLEAR, when clear is asserted.
- FOLLOW→HOLD and CLEAR→HOLD, when the strobes are released.

The registered state records the previous cycle's mode.

Top module: `qdac_front`

## Requirements
- R1: With `cs_n` and `wr1_n` both low, address 0, 1, 2 and 3 opens the staging register of channel 0, 1, 2 and 3 respectively, and only that one.
- R2: A staging register keeps its contents when `cs_n` or `wr1_n` is high, or when it is not addressed.
- R3: With `word_mode` = 1, an opened staging register takes `bus_d[11:0]` unchanged.
- R4: With `word_mode` = 0, an opened staging register takes `bus_d[11:8]` into bits 3..0 and keeps its bits 11..4. Writing `0xAB0` in word mode and then `0xC00` in byte mode gives `0xABC`.
- R5: While `wr2_n` and `xfer_n` are low and `clr_n` is high, all four outputs equal their staging values in the same cycle.
- R6: While `wr2_n` and `clr_n` are low, all four outputs are `0x800`, whatever `xfer_n` is.
- R7: A clear applied with `xfer_n` high persists: the outputs stay `0x800` after the strobes are released.
- R8: A clear pulsed while transfer is held is temporary: after `clr_n` returns high, each output shows its staging value again.
- R9: Reset, active-low and synchronous, sets every output register and every staging register to `0x800`.
- R10: With `cs_n`, `wr1_n`, `wr2_n` and `xfer_n` all low and `word_mode` = 1, the addressed channel's output equals `bus_d` in the same cycle.
- R11: With `wr2_n` high, or with both `xfer_n` and `clr_n` high, the outputs keep their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on model) |
| bus_d | input | 12 | Parallel data bus |
| addr | input | 2 | Channel select for staging writes |
| word_mode | input | 1 | 1: full 12-bit write, 0: low-nibble write from bus bits 11..8 |
| cs_n | input | 1 | Chip select, active low |
| wr1_n | input | 1 | Staging write strobe, active low |
| wr2_n | input | 1 | Output-stage strobe, active low |
| xfer_n | input | 1 | Transfer qualifier, active low |
| clr_n | input | 1 | Clear qualifier, active low |
| dac_code | output | 4x12 | Offset-binary code for each channel, channel 0 in the low word |

## Verification
Some behaviour is checked by assertions on every cycle:
- the word and byte loading rules of each staging register, and the holding of an unopened one;
- midscale during clear;
- output tracking during transfer;
- an output that stays at midscale, or at the value it last tracked, once the strobes drop back to hold;
- the fully transparent bus-to-output path.

Other behaviour can only be shown by the bench's scenarios:
- a word assembled from two byte-mode writes;
- the address decode for all four channels;
- the persistence of a clear applied with transfer high;
- the recovery of the staging values after a clear pulsed while transfer is held;
- long random strobe mixes compared against a reference model.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_FOLLOW = 2'd1,
        ST_CLEAR  = 2'd2
    } stage_mode_e;

    function automatic logic [31:0] midscale_of(input int width);
        return 32'd1 << (width - 1);
    endfunction
endpackage

// File: rtl/qdac_in_latch.sv
module qdac_in_latch #(
    parameter int DATA_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              word_mode,
    input  logic [DATA_W-1:0] bus_d,
    output logic [DATA_W-1:0] view_o
);
    import qdac_pkg::*;

    localparam int LO_W = DATA_W - BYTE_W;
    localparam logic [DATA_W-1:0] MID = DATA_W'(midscale_of(DATA_W));

    logic [DATA_W-1:0] stage_q;
    logic [DATA_W-1:0] stage_d;

    // Byte mode moves the top bus nibble into the low field only.
    always_comb begin
        stage_d = stage_q;
        if (wr_en) begin
            if (word_mode) begin
                stage_d = bus_d;
            end else begin
                stage_d[LO_W-1:0] = bus_d[DATA_W-1 -: LO_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= MID;
        end else if (wr_en) begin
            stage_q <= stage_d;
        end
    end

    assign view_o = stage_d;

    // R3
    a_r3_word_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word_mode) |=> (stage_q == $past(bus_d)));

    // R4
    a_r4_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !word_mode) |=> (stage_q[DATA_W-1:LO_W] == $past(stage_q[DATA_W-1:LO_W])));

    // R4
    a_r4_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !word_mode) |=> (stage_q[LO_W-1:0] == $past(bus_d[DATA_W-1 -: LO_W])));

    // R2
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (stage_q == $past(stage_q)));
endmodule

// File: rtl/qdac_xfer_ctrl.sv
module qdac_xfer_ctrl (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr2_n,
    input  logic                  xfer_n,
    input  logic                  clr_n,
    output qdac_pkg::stage_mode_e mode_o,
    output qdac_pkg::stage_mode_e prev_o
);
    import qdac_pkg::*;

    stage_mode_e state_q;
    stage_mode_e state_d;

    // Clear takes priority over transfer.
    always_comb begin
        if (!wr2_n && !clr_n) begin
            state_d = ST_CLEAR;
        end else if (!wr2_n && !xfer_n) begin
            state_d = ST_FOLLOW;
        end else begin
            state_d = ST_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    assign mode_o = state_d;
    assign prev_o = state_q;
endmodule

// File: rtl/qdac_dac_latch.sv
module qdac_dac_latch #(
    parameter int DATA_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  qdac_pkg::stage_mode_e mode,
    input  qdac_pkg::stage_mode_e prev_mode,
    input  logic [DATA_W-1:0]     in_view,
    output logic [DATA_W-1:0]     code_o
);
    import qdac_pkg::*;

    localparam logic [DATA_W-1:0] MID = DATA_W'(midscale_of(DATA_W));

    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] out_d;

    always_comb begin
        unique case (mode)
            ST_CLEAR:  out_d = MID;
            ST_FOLLOW: out_d = in_view;
            ST_HOLD:   out_d = out_q;
            default:   out_d = out_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= MID;
        end else begin
            out_q <= out_d;
        end
    end

    assign code_o = out_d;

    // R6
    a_r6_clear_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_CLEAR) |-> (code_o == MID));

    // R5
    a_r5_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_FOLLOW) |-> (code_o == in_view));

    // R7
    a_r7_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_mode == ST_CLEAR && mode == ST_HOLD) |-> (code_o == MID));

    // R11
    a_r11_hold_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_mode == ST_FOLLOW && mode == ST_HOLD) |-> (code_o == $past(in_view)));
endmodule

// File: rtl/qdac_front.sv
module qdac_front #(
    parameter int DATA_W = 12,
    parameter int BYTE_W = 8,
    parameter int NUM_CH = 4,
    parameter int ADDR_W = $clog2(NUM_CH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DATA_W-1:0]             bus_d,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          word_mode,
    input  logic                          cs_n,
    input  logic                          wr1_n,
    input  logic                          wr2_n,
    input  logic                          xfer_n,
    input  logic                          clr_n,
    output logic [NUM_CH-1:0][DATA_W-1:0] dac_code
);
    import qdac_pkg::*;

    stage_mode_e mode;
    stage_mode_e prev_mode;
    logic [NUM_CH-1:0]             wr_en;
    logic [NUM_CH-1:0][DATA_W-1:0] stage_view;

    qdac_xfer_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr2_n  (wr2_n),
        .xfer_n (xfer_n),
        .clr_n  (clr_n),
        .mode_o (mode),
        .prev_o (prev_mode)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign wr_en[ch] = !cs_n && !wr1_n && (addr == ADDR_W'(ch));

        qdac_in_latch #(
            .DATA_W (DATA_W),
            .BYTE_W (BYTE_W)
        ) u_in (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en[ch]),
            .word_mode (word_mode),
            .bus_d     (bus_d),
            .view_o    (stage_view[ch])
        );

        qdac_dac_latch #(
            .DATA_W (DATA_W)
        ) u_out (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (mode),
            .prev_mode (prev_mode),
            .in_view   (stage_view[ch]),
            .code_o    (dac_code[ch])
        );
    end

    // R10
    a_r10_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr1_n && !wr2_n && !xfer_n && clr_n && word_mode)
            |-> (dac_code[addr] == bus_d));
endmodule

// File: tb/qdac_front_tb.sv
`timescale 1ns/1ps
module qdac_front_tb;
    localparam int DW = 12;
    localparam int NC = 4;
    localparam logic [DW-1:0] MID = 12'h800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0] bus_d = '0;
    logic [1:0] addr = '0;
    logic word_mode = 1'b1;
    logic cs_n = 1'b1, wr1_n = 1'b1, wr2_n = 1'b1, xfer_n = 1'b1, clr_n = 1'b1;
    logic [NC-1:0][DW-1:0] dac_code;

    int checks = 0;
    int errors = 0;
    string cur_req = "R9";
    logic [DW-1:0] ref_in [NC];
    logic [DW-1:0] ref_dac [NC];

    always #2.5 clk = ~clk;

    qdac_front u_dut (
        .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .addr(addr), .word_mode(word_mode),
        .cs_n(cs_n), .wr1_n(wr1_n), .wr2_n(wr2_n), .xfer_n(xfer_n), .clr_n(clr_n),
        .dac_code(dac_code)
    );

    function automatic logic [DW-1:0] f_view(int ch);
        if (cs_n || wr1_n || addr != 2'(ch)) return ref_in[ch];
        if (word_mode) return bus_d;
        return {ref_in[ch][11:4], bus_d[11:8]};
    endfunction

    function automatic logic [DW-1:0] f_dac(int ch);
        if (!wr2_n && !clr_n) return MID;
        if (!wr2_n && !xfer_n) return f_view(ch);
        return ref_dac[ch];
    endfunction

    task automatic chk(string req, int ch, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s ch%0d actual %h expected %h", req, ch, act, exp);
        end
    endtask

    task automatic tick();
        logic [DW-1:0] ni [NC];
        logic [DW-1:0] nd [NC];
        #1;
        for (int c = 0; c < NC; c++) begin
            chk(cur_req, c, dac_code[c], f_dac(c));
            ni[c] = f_view(c);
            nd[c] = f_dac(c);
        end
        @(posedge clk);
        for (int c = 0; c < NC; c++) begin
            ref_in[c]  = rst_n ? ni[c] : MID;
            ref_dac[c] = rst_n ? nd[c] : MID;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        cs_n = 1'b1; wr1_n = 1'b1; wr2_n = 1'b1; xfer_n = 1'b1; clr_n = 1'b1;
        word_mode = 1'b1;
    endtask

    task automatic wr(int ch, logic [DW-1:0] val, logic wm);
        addr = 2'(ch); bus_d = val; word_mode = wm; cs_n = 1'b0; wr1_n = 1'b0;
        tick();
        idle();
        tick();
    endtask

    task automatic xfer();
        wr2_n = 1'b0; xfer_n = 1'b0;
        tick();
        idle();
        tick();
    endtask

    initial begin : watchdog
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] words [NC];
        void'($urandom(32'd1234));
        for (int c = 0; c < NC; c++) begin
            ref_in[c] = MID;
            ref_dac[c] = MID;
        end
        @(negedge clk);
        idle();

        // R9 reset state
        cur_req = "R9";
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        for (int c = 0; c < NC; c++) chk("R9", c, dac_code[c], MID);
        tick();
        xfer();
        for (int c = 0; c < NC; c++) chk("R9 staging", c, dac_code[c], MID);

        // R3 full word, R2 other channels untouched
        cur_req = "R3";
        wr(2, 12'h5A3, 1'b1);
        #1 chk("R11 before transfer", 2, dac_code[2], MID);
        xfer();
        chk("R3", 2, dac_code[2], 12'h5A3);
        chk("R2", 0, dac_code[0], MID);

        // R4 byte assembly
        cur_req = "R4";
        wr(1, 12'hAB0, 1'b1);
        wr(1, 12'hC00, 1'b0);
        xfer();
        chk("R4", 1, dac_code[1], 12'hABC);

        // R1 address decode of every channel, R5 simultaneous transfer
        cur_req = "R1";
        words[0] = 12'h111; words[1] = 12'h7FE; words[2] = 12'hF0F; words[3] = 12'h001;
        for (int c = 0; c < NC; c++) wr(c, words[c], 1'b1);
        for (int c = 0; c < NC; c++) chk("R11 not yet transferred", c, dac_code[c], ref_dac[c]);
        cur_req = "R5";
        wr2_n = 1'b0; xfer_n = 1'b0;
        #1;
        for (int c = 0; c < NC; c++) chk("R5 R1", c, dac_code[c], words[c]);
        tick();
        idle();
        tick();

        // R6 R7 sticky clear
        cur_req = "R7";
        wr2_n = 1'b0; clr_n = 1'b0;
        #1;
        for (int c = 0; c < NC; c++) chk("R6", c, dac_code[c], MID);
        tick();
        idle();
        repeat (3) tick();
        for (int c = 0; c < NC; c++) chk("R7", c, dac_code[c], MID);

        // R8 temporary clear with transfer held
        cur_req = "R8";
        wr2_n = 1'b0; xfer_n = 1'b0;
        tick();
        clr_n = 1'b0;
        #1;
        for (int c = 0; c < NC; c++) chk("R6 over transfer", c, dac_code[c], MID);
        tick();
        clr_n = 1'b1;
        #1;
        for (int c = 0; c < NC; c++) chk("R8", c, dac_code[c], words[c]);
        tick();
        idle();
        tick();

        // R10 fully transparent path
        cur_req = "R10";
        cs_n = 1'b0; wr1_n = 1'b0; wr2_n = 1'b0; xfer_n = 1'b0; word_mode = 1'b1;
        addr = 2'd3; bus_d = 12'h123;
        #1 chk("R10", 3, dac_code[3], 12'h123);
        bus_d = 12'h456;
        #1 chk("R10", 3, dac_code[3], 12'h456);
        tick();
        idle();
        tick();
        chk("R11 after transparent", 3, dac_code[3], 12'h456);

        // Random mix against the model (R1 R2 R5 R6 R11)
        cur_req = "R11 random";
        for (int i = 0; i < 3000; i++) begin
            bus_d     = DW'($urandom);
            addr      = 2'($urandom);
            word_mode = 1'($urandom);
            cs_n      = ($urandom % 3) != 0;
            wr1_n     = ($urandom % 3) != 0;
            wr2_n     = ($urandom % 3) != 0;
            xfer_n    = ($urandom % 2) != 0;
            clr_n     = ($urandom % 5) != 0;
            tick();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule